// File: doc/BRIEF.md
# Pipeline Data Hazard Interlock

This unit guards the operands of the instruction in decode in a five-stage in-order pipeline with eight architectural registers. Each cycle it compares the two source register numbers of the decoding instruction with the destination of every older instruction that can still write a register: the ones in execute, memory and writeback. From these matches it decides two things. The first is whether decode must be frozen. The second is which copy of each operand the ALU should use once the instruction reaches execute.

The `stall` output is combinational and acts in the same cycle. It holds the fetch and decode pipeline registers, and its registered copy `ex_bubble` marks the noop that enters execute. The operand selects are registered together with the instruction as it moves into execute. They drive the muxes in front of the two ALU inputs.

A build parameter picks one of two modes. In stall-only mode every close dependence is resolved by waiting. In forwarding mode results are bypassed, and only a load followed directly by a user of its result costs a cycle. The register file, ALU and memories lie outside the unit and appear only as the signals below.

Top module: `hazard_interlock`

## Requirements
- R1: While `rst` is high, a clock edge sets `ex_sel_a`, `ex_sel_b` and `ex_bubble` to 0, whatever the other inputs are.
- R2: An older stage can match only when both its valid and write-enable inputs are 1. A match means that its 3-bit destination equals the 3-bit source number.
- R3: In forwarding mode, suppose a non-load instruction in execute writes a register that a valid decoding instruction reads. Then `stall` stays 0, and after the next edge the select for that operand is 1, the execute/memory result.
- R4: In forwarding mode each select picks the youngest matching writer. The codes are 1 for a match in execute, 2 for a match in memory (the memory/writeback register), 3 for a match in writeback (the writeback output latch) and 0 for the register file when nothing matches.
- R5: In forwarding mode `stall` is 1 in the same cycle exactly when a valid decoding instruction reads the destination of a load in execute. No other case raises `stall`.
- R6: After an edge with `stall` at 1, `ex_bubble` is 1 and both selects are 0. After an edge with `stall` at 0, `ex_bubble` is 0.
- R7: In stall-only mode `stall` is 1 when either source matches the writer in execute or in memory, whether or not it is a load. A match in writeback alone never stalls, and both selects are always 0.
- R8: The two operands are resolved independently, each with its own select. `stall` is 1 if either operand needs it.
- R9: When `dec_valid` is 0, `stall` is 0, and after the next edge both selects and `ex_bubble` are 0.
- R10: Take an instruction that directly follows its producer. In stall-only mode it is held for two stall cycles. In forwarding mode it is held for none, or for one when the producer is a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_src_a | input | 3 | First source register of the decoding instruction |
| dec_src_b | input | 3 | Second source register of the decoding instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_we | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| ex_dest | input | 3 | Destination of the instruction in execute |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_we | input | 1 | Instruction in memory writes a register |
| mem_dest | input | 3 | Destination of the instruction in memory |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_we | input | 1 | Instruction in writeback writes a register |
| wb_dest | input | 3 | Destination of the instruction in writeback |
| stall | output | 1 | Freeze fetch and decode this cycle |
| ex_sel_a | output | 2 | Operand A source in execute: 0 register file, 1 execute/memory, 2 memory/writeback, 3 writeback latch |
| ex_sel_b | output | 2 | Operand B source in execute, same encoding |
| ex_bubble | output | 1 | Execute holds an inserted noop |

## Verification
Two things can happen in the same cycle. A load-use stall raised by one operand can coincide with a forward that the other operand would take from a deeper stage. The bench provokes this by pointing operand A at a load in execute while operand B matches the memory or writeback writer. It also sweeps thousands of mixed patterns in which such overlaps happen at random. The correct outcome is `stall` high in that cycle, followed by a bubble with both selects at 0, because the forward must be recomputed after the freeze. The bench also walks a dependent instruction down the pipeline behind its producer and counts its stall cycles in both modes.

// File: rtl/hzi_pkg.sv
`timescale 1ns/1ps
package hzi_pkg;
  // Number of older pipeline stages that may hold a register writer.
  // Index 0 is execute, 1 is memory, 2 is writeback (youngest first).
  localparam int NUM_OLDER = 3;
  localparam int NUM_OPS   = 2;

  // ALU operand source, registered into execute with the instruction.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_EXMEM   = 2'd1,
    SRC_MEMWB   = 2'd2,
    SRC_WBLATCH = 2'd3
  } opnd_src_e;
endpackage

// File: rtl/hzi_writer_match.sv
`timescale 1ns/1ps
// One source operand compared with every older writer (R2).
module hzi_writer_match
  import hzi_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0]                src,
  input  logic [NUM_OLDER-1:0][REG_W-1:0] dest,
  input  logic [NUM_OLDER-1:0]            live,
  output logic [NUM_OLDER-1:0]            hit
);
  for (genvar s = 0; s < NUM_OLDER; s++) begin : g_cmp
    assign hit[s] = live[s] && (dest[s] == src);
  end
endmodule

// File: rtl/hzi_operand_resolve.sv
`timescale 1ns/1ps
// Turns the per-stage matches of one operand into a source select and
// a stall request. The mode parameter selects the policy masks.
module hzi_operand_resolve
  import hzi_pkg::*;
#(
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic [NUM_OLDER-1:0] hit,
  input  logic                 ex_load,
  output opnd_src_e            sel,
  output logic                 need_stall
);
  // Stages whose result can reach the ALU by a bypass path.
  localparam logic [NUM_OLDER-1:0] FWD_OK     = FORWARD_EN ? 3'b111 : 3'b000;
  // Stages that force a wait regardless of instruction kind (R7).
  localparam logic [NUM_OLDER-1:0] WAIT_ANY   = FORWARD_EN ? 3'b000 : 3'b011;
  // Stages that force a wait only when they hold a load (R5).
  localparam logic [NUM_OLDER-1:0] WAIT_LOAD  = FORWARD_EN ? 3'b001 : 3'b000;

  logic [NUM_OLDER-1:0] fwd_hit;
  logic [NUM_OLDER-1:0] late_mask;

  assign late_mask  = {{(NUM_OLDER-1){1'b0}}, ex_load};
  assign fwd_hit    = hit & FWD_OK;
  assign need_stall = |(hit & (WAIT_ANY | (WAIT_LOAD & late_mask)));

  // Youngest writer wins (R4).
  always_comb begin
    if (fwd_hit[0])      sel = SRC_EXMEM;
    else if (fwd_hit[1]) sel = SRC_MEMWB;
    else if (fwd_hit[2]) sel = SRC_WBLATCH;
    else                 sel = SRC_REGFILE;
  end
endmodule

// File: rtl/hazard_interlock.sv
`timescale 1ns/1ps
module hazard_interlock
  import hzi_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter bit FORWARD_EN = 1'b1,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             ex_valid,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_dest,
  input  logic             mem_valid,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_dest,
  input  logic             wb_valid,
  input  logic             wb_we,
  input  logic [REG_W-1:0] wb_dest,
  output logic             stall,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b,
  output logic             ex_bubble
);
  logic [NUM_OLDER-1:0][REG_W-1:0] older_dest;
  logic [NUM_OLDER-1:0]            older_live;
  logic [NUM_OPS-1:0][REG_W-1:0]   src;
  logic [NUM_OPS-1:0][NUM_OLDER-1:0] hit;
  logic [NUM_OPS-1:0]              op_stall;
  opnd_src_e                       op_sel [NUM_OPS];
  opnd_src_e                       sel_q  [NUM_OPS];
  logic                            bubble_q;
  logic                            stall_w;

  // Only real instructions that write a register are writers (R2).
  assign older_dest = {wb_dest, mem_dest, ex_dest};
  assign older_live = {wb_valid & wb_we, mem_valid & mem_we, ex_valid & ex_we};
  assign src        = {dec_src_b, dec_src_a};

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    hzi_writer_match #(.REG_W(REG_W)) u_match (
      .src  (src[op]),
      .dest (older_dest),
      .live (older_live),
      .hit  (hit[op])
    );
    hzi_operand_resolve #(.FORWARD_EN(FORWARD_EN)) u_resolve (
      .hit        (hit[op]),
      .ex_load    (ex_load),
      .sel        (op_sel[op]),
      .need_stall (op_stall[op])
    );
  end

  // Either operand can freeze decode (R8); an empty slot never does (R9).
  assign stall_w = dec_valid && (|op_stall);

  // Selects travel with the instruction into execute; a stall sends a
  // noop with register-file selects instead (R6, R1).
  always_ff @(posedge clk) begin
    if (rst) begin
      bubble_q <= 1'b0;
      for (int op = 0; op < NUM_OPS; op++) sel_q[op] <= SRC_REGFILE;
    end else begin
      bubble_q <= stall_w;
      for (int op = 0; op < NUM_OPS; op++)
        sel_q[op] <= (dec_valid && !stall_w) ? op_sel[op] : SRC_REGFILE;
    end
  end

  assign stall     = stall_w;
  assign ex_bubble = bubble_q;
  assign ex_sel_a  = sel_q[0];
  assign ex_sel_b  = sel_q[1];

  // ---------------- assertions ----------------
  assert_idle_decode_R9: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!stall ##1 (ex_sel_a == 2'd0 && ex_sel_b == 2'd0 && !ex_bubble)));

  assert_bubble_after_stall_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ex_bubble && ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

  assert_no_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    !stall |=> !ex_bubble);

  assert_dead_writer_R2: assert property (@(posedge clk) disable iff (rst)
    (!(ex_valid && ex_we) && !(mem_valid && mem_we) && !(wb_valid && wb_we))
      |-> (!stall ##1 (ex_sel_a == 2'd0 && ex_sel_b == 2'd0)));

  if (FORWARD_EN) begin : g_fwd_chk
    assert_stall_only_load_R5: assert property (@(posedge clk) disable iff (rst)
      stall |-> (ex_valid && ex_we && ex_load));

    assert_load_use_R5: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && ex_valid && ex_we && ex_load && dec_src_b == ex_dest) |-> stall);

    assert_ex_wins_R4: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && ex_valid && ex_we && !ex_load && dec_src_a == ex_dest && !stall)
        |=> (ex_sel_a == 2'd1));
  end else begin : g_stall_chk
    assert_sel_rf_R7: assert property (@(posedge clk) disable iff (rst)
      (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

    assert_wait_mem_R7: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && mem_valid && mem_we && dec_src_a == mem_dest) |-> stall);
  end
endmodule

// File: tb/hazard_interlock_bench.sv
`timescale 1ns/1ps
module hazard_interlock_bench;
  typedef struct packed {
    logic       dv;
    logic [2:0] sa, sb;
    logic       ev, ew, el;
    logic [2:0] ed;
    logic       mv, mw;
    logic [2:0] md;
    logic       wv, ww;
    logic [2:0] wd;
  } vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  vec_t v;
  int checks = 0;
  int errors = 0;

  logic       f_stall, s_stall, f_bub, s_bub;
  logic [1:0] f_sa, f_sb, s_sa, s_sb;

  always #5 clk = ~clk;

  hazard_interlock #(.FORWARD_EN(1'b1)) u_hazard_interlock (
    .clk(clk), .rst(rst), .dec_valid(v.dv), .dec_src_a(v.sa), .dec_src_b(v.sb),
    .ex_valid(v.ev), .ex_we(v.ew), .ex_load(v.el), .ex_dest(v.ed),
    .mem_valid(v.mv), .mem_we(v.mw), .mem_dest(v.md),
    .wb_valid(v.wv), .wb_we(v.ww), .wb_dest(v.wd),
    .stall(f_stall), .ex_sel_a(f_sa), .ex_sel_b(f_sb), .ex_bubble(f_bub));

  hazard_interlock #(.FORWARD_EN(1'b0)) u_hazard_interlock_so (
    .clk(clk), .rst(rst), .dec_valid(v.dv), .dec_src_a(v.sa), .dec_src_b(v.sb),
    .ex_valid(v.ev), .ex_we(v.ew), .ex_load(v.el), .ex_dest(v.ed),
    .mem_valid(v.mv), .mem_we(v.mw), .mem_dest(v.md),
    .wb_valid(v.wv), .wb_we(v.ww), .wb_dest(v.wd),
    .stall(s_stall), .ex_sel_a(s_sa), .ex_sel_b(s_sb), .ex_bubble(s_bub));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Expected operand outcome from the requirements: {stall_req, sel}.
  function automatic logic [2:0] exp_op(input bit fwd, input logic [2:0] s, input vec_t x);
    logic he, hm, hw;
    he = x.ev && x.ew && (x.ed == s);      // R2
    hm = x.mv && x.mw && (x.md == s);
    hw = x.wv && x.ww && (x.wd == s);
    if (fwd) return {he && x.el, he ? 2'd1 : hm ? 2'd2 : hw ? 2'd3 : 2'd0};
    else     return {he || hm, 2'd0};
  endfunction

  // Drive one decode cycle and check both modes.
  task automatic apply(input vec_t x);
    logic [2:0] fa, fb, sa3, sb3;
    logic ef, es;
    @(negedge clk);
    v = x;
    fa = exp_op(1'b1, x.sa, x); fb = exp_op(1'b1, x.sb, x);
    sa3 = exp_op(1'b0, x.sa, x); sb3 = exp_op(1'b0, x.sb, x);
    ef = x.dv && (fa[2] || fb[2]);
    es = x.dv && (sa3[2] || sb3[2]);
    #1;
    chk("R5 forward-mode stall", f_stall, ef);
    chk("R7 stall-only stall", s_stall, es);
    @(posedge clk); #1;
    chk("R6 forward-mode bubble", f_bub, ef);
    chk("R6 stall-only bubble", s_bub, es);
    chk("R4 sel a", f_sa, (x.dv && !ef) ? fa[1:0] : 0);
    chk("R8 sel b", f_sb, (x.dv && !ef) ? fb[1:0] : 0);
    chk("R7 sel a rf", s_sa, 0);
    chk("R7 sel b rf", s_sb, 0);
  endtask

  function automatic vec_t quiet();
    vec_t q;
    q = '0;
    q.dv = 1'b1; q.sa = 3'd1; q.sb = 3'd2;
    q.ev = 1; q.ew = 1; q.ed = 3'd5;
    q.mv = 1; q.mw = 1; q.md = 3'd6;
    q.wv = 1; q.ww = 1; q.wd = 3'd7;
    return q;
  endfunction

  // Producer writing r3 moves down while the consumer is held (R10).
  task automatic walk(input bit load, output int f_cnt, output int s_cnt);
    vec_t x;
    f_cnt = 0; s_cnt = 0;
    for (int pos = 0; pos < 4; pos++) begin
      x = quiet();
      x.sa = 3'd3; x.el = 1'b0;
      if (pos == 0) begin x.ed = 3'd3; x.el = load; end
      if (pos == 1) x.md = 3'd3;
      if (pos == 2) x.wd = 3'd3;
      @(negedge clk); v = x; #1;
      if (f_stall && pos == f_cnt) f_cnt++;
      if (s_stall && pos == s_cnt) s_cnt++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run incomplete actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    vec_t x;
    logic [31:0] lfsr;
    int fc, sc;
    // R1: reset with a load-use pattern present.
    x = quiet(); x.sa = 3'd5; x.el = 1'b1; x.sb = 3'd6;
    v = x;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 bubble in reset", f_bub, 0);
    chk("R1 sel a in reset", f_sa, 0);
    chk("R1 sel b in reset", f_sb, 0);
    chk("R1 stall-only bubble in reset", s_bub, 0);
    @(negedge clk); rst = 1'b0;

    // R3: non-load in execute forwarded without stall.
    x = quiet(); x.sa = 3'd5; apply(x); chk("R3 sel a exmem", f_sa, 1);
    // R4: priority ladder on operand a.
    x = quiet(); x.ed = 3'd4; x.md = 3'd4; x.wd = 3'd4; x.sa = 3'd4; apply(x);
    chk("R4 youngest wins", f_sa, 1);
    x.ed = 3'd0; apply(x); chk("R4 memwb over wb", f_sa, 2);
    x.md = 3'd0; apply(x); chk("R4 wb latch", f_sa, 3);
    // R2: dead writers do not match.
    x = quiet(); x.sa = 3'd5; x.ew = 0; x.sb = 3'd6; x.mv = 0; apply(x);
    chk("R2 no-write ex", f_sa, 0);
    chk("R2 invalid mem", f_sb, 0);
    chk("R2 stall-only no stall", s_bub, 0);
    // R5: load-use; overlap with a deeper forward on operand b.
    x = quiet(); x.el = 1; x.sa = 3'd5; x.sb = 3'd6; apply(x);
    chk("R5 load-use bubble", f_bub, 1);
    chk("R8 b dropped on stall", f_sb, 0);
    // R8: independent sources.
    x = quiet(); x.sa = 3'd6; x.sb = 3'd7; apply(x);
    chk("R8 a from memwb", f_sa, 2);
    chk("R8 b from wb", f_sb, 3);
    // R9: empty decode.
    x = quiet(); x.dv = 0; x.el = 1; x.sa = 3'd5; apply(x);
    chk("R9 no bubble", f_bub, 0);
    // R7: wb-only match does not stall in stall-only mode.
    x = quiet(); x.sa = 3'd7; apply(x); chk("R7 wb no stall", s_bub, 0);

    // R10: stall counts behind a producer.
    walk(1'b0, fc, sc);
    chk("R10 forward non-load stalls", fc, 0);
    chk("R10 stall-only stalls", sc, 2);
    walk(1'b1, fc, sc);
    chk("R10 forward load stalls", fc, 1);

    // Exhaustive slice: operand a against execute writer, all flags.
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        for (int f = 0; f < 8; f++) begin
          x = quiet(); x.sa = 3'(s); x.ed = 3'(d);
          x.ev = f[0]; x.ew = f[1]; x.el = f[2];
          x.md = 3'(d ^ 1); x.wd = 3'(d ^ 2);
          apply(x);
        end

    // Pseudo-random sweep over all fields.
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = vec_t'(lfsr[24:0] ^ 25'(i * 7919));
      x.dv = x.dv | lfsr[28];
      apply(x);
    end

    summary();
    $finish;
  end
endmodule